// File: doc/BRIEF.md
# Sticky Status Flag Register

This block holds a 16-bit processor status word for a microcoded sequencer. The sequencer sets, clears and tests single bits by a 4-bit index. Three external sources also reach the word. A battery-low input sets bit 5. A keyboard-controller flag sets bit 3. A program-mode switch also sets bit 3, but only while bit 0 is set. Each external source sets its bit while it is active. When the source goes inactive the bit stays set, and only a clear command from the sequencer removes it.

Bit 0 drives the single flag output pin. It also drives a two-way memory bank select, so the microcode switches ROM banks by setting or clearing bit 0 rather than by a dedicated instruction. Every external input passes through a two-flop synchronizer before it reaches the set logic. A pin that goes active before rising edge k therefore shows in the status word after edge k+2.

Top module: `status_flag_reg`

## Requirements
- R1: While `rstN` is low, all 16 status bits, `flagOut`, `bankSel` and `testResult` are 0.
- R2: A set command (`setEn`=1) sets bit `bitIdx` on the next rising edge and leaves every other bit unchanged.
- R3: A clear command (`clrEn`=1) clears bit `bitIdx` on the next rising edge and leaves every other bit unchanged.
- R4: A test (`testEn`=1) loads `testResult` on the next rising edge with the value bit `bitIdx` had in the request cycle. Without a test, `testResult` holds its value.
- R5: When a set, from a command or from a pin, and a clear reach the same bit in one cycle, the bit ends up 0. A pin that is still active sets the bit again on the following edge.
- R6: Setting `battLow` high sets bit 5. The bit reads 0 after two rising edges and 1 after the third, counting from the cycle in which the input rose.
- R7: Bits set by external inputs stay set after the input returns low, until a clear command hits them.
- R8: Setting `kbdFlag` high sets bit 3, with the same synchronizer latency as R6.
- R9: Holding `progMode` high sets bit 3 only while bit 0 is 1. With bit 0 at 0, the switch has no effect on bit 3.
- R10: `flagOut` and `bankSel` both equal status bit 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| setEn | input | 1 | Set the bit selected by bitIdx |
| clrEn | input | 1 | Clear the bit selected by bitIdx |
| testEn | input | 1 | Sample the bit selected by bitIdx into testResult |
| bitIdx | input | 4 | Bit index for set, clear and test |
| battLow | input | 1 | Battery-low flag input, active high, sets bit 5 |
| kbdFlag | input | 1 | Keyboard-controller flag, active high, sets bit 3 |
| progMode | input | 1 | Program-mode switch, active high, sets bit 3 when bit 0 is set |
| statusBits | output | 16 | Current status word |
| testResult | output | 1 | Registered result of the last test |
| flagOut | output | 1 | Flag output pin, follows bit 0 |
| bankSel | output | 1 | Memory bank select, follows bit 0 |

## Verification
Two functions can hit the same bit in one cycle: a set, from a command or from a held pin, and a clear command. The bench issues `setEn` and `clrEn` together on one index and expects the bit to read 0. It then holds `battLow` high, waits until bit 5 is set, and issues a clear of bit 5. Bit 5 must read 0 right after the clear's edge and 1 again one edge later.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
  localparam int STAT_W = 16;
  localparam int IDX_W  = $clog2(STAT_W);

  typedef struct packed {
    logic [STAT_W-1:0] setMask;
    logic [STAT_W-1:0] clrMask;
    logic              testStb;
    logic [IDX_W-1:0]  testIdx;
  } strobe_t;
endpackage

// File: rtl/stflag_ctrl.sv
module stflag_ctrl
  import stflag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             setEn,
  input  logic             clrEn,
  input  logic             testEn,
  input  logic [IDX_W-1:0] bitIdx,
  output strobe_t          strb
);
  logic [STAT_W-1:0] idxOneHot;

  always_comb begin
    idxOneHot = '0;
    idxOneHot[bitIdx] = 1'b1;
  end

  always_comb begin
    strb.setMask = setEn ? idxOneHot : '0;
    strb.clrMask = clrEn ? idxOneHot : '0;
    strb.testStb = testEn;
    strb.testIdx = bitIdx;
  end

  // R2/R3: commands touch at most one bit
  a_r2_set_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.setMask));
  a_r3_clr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clrMask));
endmodule

// File: rtl/stflag_dp.sv
module stflag_dp
  import stflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BATT_BIT    = 5,
  parameter int KBD_BIT     = 3,
  parameter int GATE_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              battLow,
  input  logic              kbdFlag,
  input  logic              progMode,
  output logic [STAT_W-1:0] statusQ,
  output logic              testQ
);
  localparam int NUM_EXT = 3;

  logic [NUM_EXT-1:0] extRaw;
  logic [NUM_EXT-1:0] extSync;
  logic [STAT_W-1:0]  pinSetMask;
  logic [STAT_W-1:0]  statusD;

  assign extRaw = {progMode, kbdFlag, battLow};

  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], extRaw[g]};
      end
      assign extSync[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  logic battS, kbdS, progS;
  assign battS = extSync[0];
  assign kbdS  = extSync[1];
  assign progS = extSync[2];

  always_comb begin
    pinSetMask = '0;
    pinSetMask[BATT_BIT] = battS;
    pinSetMask[KBD_BIT]  = kbdS | (progS & statusQ[GATE_BIT]);
  end

  // clear has priority over any set source
  assign statusD = (statusQ | strb.setMask | pinSetMask) & ~strb.clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      testQ   <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (strb.testStb) testQ <= statusQ[strb.testIdx];
    end
  end

  // R7: without a clear no set bit falls
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~strb.clrMask) != '0) |=>
      ((statusQ & $past(statusQ & ~strb.clrMask)) == $past(statusQ & ~strb.clrMask)));
  // R5: cleared bit reads 0 afterwards whatever sets it
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMask != '0) |=> ((statusQ & $past(strb.clrMask)) == '0));
  // R6: synchronized battery flag sets its bit
  a_r6_batt_sets: assert property (@(posedge clk) disable iff (!rstN)
    (battS && !strb.clrMask[BATT_BIT]) |=> statusQ[BATT_BIT]);
  // R9: gated switch alone cannot raise bit 3
  a_r9_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ[GATE_BIT] && !kbdS && !strb.setMask[KBD_BIT] && !statusQ[KBD_BIT])
      |=> !statusQ[KBD_BIT]);
  // R4: test result follows the addressed bit
  a_r4_test: assert property (@(posedge clk) disable iff (!rstN)
    strb.testStb |=> (testQ == $past(statusQ[strb.testIdx])));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import stflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BATT_BIT    = 5,
  parameter int KBD_BIT     = 3,
  parameter int GATE_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setEn,
  input  logic              clrEn,
  input  logic              testEn,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              battLow,
  input  logic              kbdFlag,
  input  logic              progMode,
  output logic [STAT_W-1:0] statusBits,
  output logic              testResult,
  output logic              flagOut,
  output logic              bankSel
);
  strobe_t strb;

  stflag_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .setEn(setEn), .clrEn(clrEn),
    .testEn(testEn), .bitIdx(bitIdx), .strb(strb)
  );

  stflag_dp #(
    .SYNC_STAGES(SYNC_STAGES), .BATT_BIT(BATT_BIT),
    .KBD_BIT(KBD_BIT), .GATE_BIT(GATE_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .battLow(battLow),
    .kbdFlag(kbdFlag), .progMode(progMode),
    .statusQ(statusBits), .testQ(testResult)
  );

  assign flagOut = statusBits[GATE_BIT];
  assign bankSel = statusBits[GATE_BIT];

  // R1: reset state at the ports
  a_r1_reset: assert property (@(posedge clk)
    !rstN |=> (statusBits == '0 && !testResult));
endmodule

// File: tb/tb_status_flag_reg.sv
module tb_status_flag_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setEn = 0, clrEn = 0, testEn = 0;
  logic [3:0] bitIdx = 0;
  logic battLow = 0, kbdFlag = 0, progMode = 0;
  logic [15:0] statusBits;
  logic testResult, flagOut, bankSel;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg dut (
    .clk(clk), .rstN(rstN), .setEn(setEn), .clrEn(clrEn), .testEn(testEn),
    .bitIdx(bitIdx), .battLow(battLow), .kbdFlag(kbdFlag), .progMode(progMode),
    .statusBits(statusBits), .testResult(testResult),
    .flagOut(flagOut), .bankSel(bankSel)
  );

  // {set, clr, test, idx, expected status, expected testResult}
  typedef struct packed {
    logic s; logic c; logic t; logic [3:0] idx;
    logic [15:0] expStat; logic expTest;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 4'd7,  16'h0080, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd15, 16'h8080, 1'b0},
    '{1'b0, 1'b0, 1'b1, 4'd7,  16'h8080, 1'b1},
    '{1'b0, 1'b1, 1'b0, 4'd7,  16'h8000, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'd7,  16'h8000, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'h8001, 1'b0},
    '{1'b1, 1'b1, 1'b0, 4'd4,  16'h8001, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd4,  16'h8011, 1'b0},
    '{1'b1, 1'b1, 1'b0, 4'd4,  16'h8001, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd15, 16'h0001, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd0,  16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic s, input logic c, input logic t, input logic [3:0] idx);
    setEn = s; clrEn = c; testEn = t; bitIdx = idx;
    tick(1);
    setEn = 0; clrEn = 0; testEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 status", statusBits, 16'h0000);
    chk("R1 test", {15'd0, testResult}, 16'd0);
    chk("R1 flagOut", {15'd0, flagOut}, 16'd0);
    chk("R1 bankSel", {15'd0, bankSel}, 16'd0);
    rstN = 1'b1;
    tick(1);

    // R2 R3 R4 R5 R10 command vectors
    for (int v = 0; v < NV; v++) begin
      cmd(VECS[v].s, VECS[v].c, VECS[v].t, VECS[v].idx);
      chk("R2/R3/R5 vector status", statusBits, VECS[v].expStat);
      chk("R4 vector test", {15'd0, testResult}, {15'd0, VECS[v].expTest});
      chk("R10 flagOut", {15'd0, flagOut}, {15'd0, VECS[v].expStat[0]});
      chk("R10 bankSel", {15'd0, bankSel}, {15'd0, VECS[v].expStat[0]});
    end

    // R6 battery latency
    battLow = 1'b1;
    tick(2);
    chk("R6 bit5 after two edges", {15'd0, statusBits[5]}, 16'd0);
    tick(1);
    chk("R6 bit5 after three edges", {15'd0, statusBits[5]}, 16'd1);
    // R5 clear against held pin
    cmd(1'b0, 1'b1, 1'b0, 4'd5);
    chk("R5 bit5 cleared", {15'd0, statusBits[5]}, 16'd0);
    tick(1);
    chk("R5 bit5 set again", {15'd0, statusBits[5]}, 16'd1);
    // R7 sticky after release
    battLow = 1'b0;
    tick(5);
    chk("R7 bit5 sticky", statusBits, 16'h0020);
    cmd(1'b0, 1'b1, 1'b0, 4'd5);
    tick(2);
    chk("R7 bit5 cleared stays", statusBits, 16'h0000);

    // R8 keyboard flag
    kbdFlag = 1'b1;
    tick(2);
    chk("R8 bit3 after two edges", {15'd0, statusBits[3]}, 16'd0);
    tick(1);
    chk("R8 bit3 after three edges", statusBits, 16'h0008);
    kbdFlag = 1'b0;
    tick(3);
    cmd(1'b0, 1'b1, 1'b0, 4'd3);
    chk("R8 bit3 cleared", statusBits, 16'h0000);

    // R9 gated switch
    progMode = 1'b1;
    tick(6);
    chk("R9 switch ignored with bit0 low", statusBits, 16'h0000);
    cmd(1'b1, 1'b0, 1'b0, 4'd0);
    chk("R9 bit0 set, bit3 not yet", statusBits, 16'h0001);
    tick(1);
    chk("R9 switch reaches bit3", statusBits, 16'h0009);
    chk("R10 bankSel high", {15'd0, bankSel}, 16'd1);
    progMode = 1'b0;
    tick(3);
    cmd(1'b0, 1'b1, 1'b0, 4'd0);
    chk("R7 bit3 kept after gate closes", statusBits, 16'h0008);
    chk("R10 flagOut low", {15'd0, flagOut}, 16'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule